// File: doc/BRIEF.md
# Wraparound Pass-Window Phase Selector

This block chooses one receive sampling phase after a tuning sweep. The sweep tries every phase of a delay line with NPH taps (16 by default) and leaves a pass mask: bit p is set when phase p sampled cleanly. The selector groups the passing phases into runs of adjacent phases. It treats the phase range as a circle, so a run that reaches the top phase is joined to a run that starts at phase zero. It then takes the longest run and returns the phase that sits about three quarters of the way through it.

A controller pulses `start` for one cycle and presents the mask on `pass_mask` in the same cycle. The block latches the mask and walks it one phase per cycle. After one closing cycle it raises either `valid` with the chosen `phase_out`, or `error` when no phase can be chosen. The result stays on the outputs until the next `start`. A new `start` is always accepted, even during a walk, and the walk then begins again on the new mask.

Top module: `phase_window_select`

## Requirements
- R1: While reset is high and after reset is released, `valid` and `error` are 0 and `phase_out` is 0 until a result is produced.
- R2: `valid` and `error` go low in the cycle after `start` is sampled. The result appears exactly NPH+1 cycles after the `start` edge (17 cycles with the default parameters).
- R3: Set bits of `pass_mask` whose indices are consecutive form one run. A new run begins at any set bit whose lower neighbour is clear. The longest run is selected, and the chosen phase is always a set bit of the mask.
- R4: When several runs share the greatest length, the one with the lowest starting phase wins.
- R5: When bit 0 and bit NPH-1 are both set and belong to different runs, the two runs form one circular run. Its elements are the run that ends at NPH-1, in order, followed by the run that starts at 0. The chosen phase is the element at the computed offset, which wraps modulo NPH.
- R6: After a merge, the run that started at phase 0 no longer competes on its own. For tie breaking, the circular run takes the place of the top run, so it loses a tie to any equal run that starts lower.
- R7: For a selected run of length L, the offset is floor(3L/4) minus one, or 0 when floor(3L/4) is 0. For example, L=14 gives offset 9 and L=1 gives offset 0.
- R8: A mask with every bit set is one ordinary run of length NPH and yields phase 11 for NPH=16.
- R9: A mask of all zeros sets `error` and leaves `valid` low. A merged circular run that would hold NPH or more phases is also an error.
- R10: `valid` and `error` are never high together. `valid`, `error` and `phase_out` hold their values until the next `start`.
- R11: A `start` sampled during a walk abandons the walk and processes the newly presented mask. Only one result is produced, and it belongs to the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches `pass_mask` and begins a selection |
| pass_mask | input | NPH | Bit p set when sampling phase p passed |
| phase_out | output | $clog2(NPH) | Selected phase, held until the next start |
| valid | output | 1 | A phase was selected |
| error | output | 1 | No phase can be selected |

## Verification
The hardest case to reach is a circular run that ties with a run in the middle of the range. It is the only place where the tie-break position of the merged run changes the answer. Masks such as 0xC0F3 and 0xF00F drive the merge, and a tied case shows that the middle run beats the circular one. A second start is also sent partway through a walk to show that the stale mask leaves no trace. A long pseudo-random mask sweep is then compared against a run-list reference model written in the bench.

// File: rtl/phsel_pkg.sv
package phsel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } phsel_state_e;

endpackage

// File: rtl/phsel_run_scanner.sv
module phsel_run_scanner #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int LW  = $clog2(NPH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          bit_in,
  input  logic [PW-1:0] idx,
  input  logic          last,
  output logic          close_v,
  output logic [PW-1:0] close_start,
  output logic [LW-1:0] close_len,
  output logic          close_end
);

  localparam logic [LW-1:0] LEN_ONE = LW'(1);

  logic          in_run;
  logic [PW-1:0] run_start;
  logic [LW-1:0] run_len;
  logic [PW-1:0] ext_start;
  logic [LW-1:0] ext_len;

  always_comb begin
    ext_start   = in_run ? run_start : idx;
    ext_len     = in_run ? (run_len + LEN_ONE) : LEN_ONE;
    close_v     = step && ((in_run && !bit_in) || (bit_in && last));
    close_start = bit_in ? ext_start : run_start;
    close_len   = bit_in ? ext_len : run_len;
    close_end   = bit_in && last;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      in_run    <= 1'b0;
      run_start <= '0;
      run_len   <= '0;
    end else if (step) begin
      if (bit_in) begin
        in_run    <= 1'b1;
        run_start <= ext_start;
        run_len   <= ext_len;
      end else begin
        in_run  <= 1'b0;
        run_len <= '0;
      end
    end
  end

endmodule

// File: rtl/phsel_window_acc.sv
module phsel_window_acc #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int LW  = $clog2(NPH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          close_v,
  input  logic [PW-1:0] close_start,
  input  logic [LW-1:0] close_len,
  input  logic          close_end,
  output logic          head_v,
  output logic [LW-1:0] head_len,
  output logic          tail_v,
  output logic [PW-1:0] tail_start,
  output logic [LW-1:0] tail_len,
  output logic [PW-1:0] mid_start,
  output logic [LW-1:0] mid_len
);

  logic at_zero;
  assign at_zero = (close_start == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head_v     <= 1'b0;
      head_len   <= '0;
      tail_v     <= 1'b0;
      tail_start <= '0;
      tail_len   <= '0;
      mid_start  <= '0;
      mid_len    <= '0;
    end else if (close_v) begin
      if (at_zero) begin
        head_v   <= 1'b1;
        head_len <= close_len;
      end
      if (close_end) begin
        tail_v     <= 1'b1;
        tail_start <= close_start;
        tail_len   <= close_len;
      end
      if (!at_zero && !close_end && (close_len > mid_len)) begin
        mid_start <= close_start;
        mid_len   <= close_len;
      end
    end
  end

endmodule

// File: rtl/phsel_resolver.sv
module phsel_resolver #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int LW  = $clog2(NPH + 1)
) (
  input  logic          head_v,
  input  logic [LW-1:0] head_len,
  input  logic          tail_v,
  input  logic [PW-1:0] tail_start,
  input  logic [LW-1:0] tail_len,
  input  logic [PW-1:0] mid_start,
  input  logic [LW-1:0] mid_len,
  output logic [PW-1:0] sel_start,
  output logic [LW-1:0] sel_len,
  output logic          fail
);

  localparam logic [LW:0] NPH_W = (LW+1)'(NPH);

  logic [LW:0] merged_len;
  logic        merge;
  logic        any_run;

  always_comb begin
    merged_len = {1'b0, head_len} + {1'b0, tail_len};
    merge      = head_v && tail_v && (tail_start != '0);
    any_run    = head_v || tail_v || (mid_len != '0);
    fail       = 1'b0;
    sel_start  = '0;
    sel_len    = '0;
    if (!any_run) begin
      fail = 1'b1;
    end else if (merge) begin
      if (merged_len >= NPH_W) begin
        fail = 1'b1;
      end else begin
        sel_start = mid_start;
        sel_len   = mid_len;
        if (merged_len > {1'b0, mid_len}) begin
          sel_start = tail_start;
          sel_len   = merged_len[LW-1:0];
        end
      end
    end else begin
      if (head_v) begin
        sel_len = head_len;
      end
      if (mid_len > sel_len) begin
        sel_start = mid_start;
        sel_len   = mid_len;
      end
      if (tail_v && (tail_start != '0) && (tail_len > sel_len)) begin
        sel_start = tail_start;
        sel_len   = tail_len;
      end
    end
  end

endmodule

// File: rtl/phsel_offset_pick.sv
module phsel_offset_pick #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int LW  = $clog2(NPH + 1)
) (
  input  logic [PW-1:0] sel_start,
  input  logic [LW-1:0] sel_len,
  output logic [PW-1:0] phase
);

  localparam int QW = LW + 2;
  localparam logic [QW-1:0] ONE_Q = QW'(1);
  localparam logic [QW-1:0] NPH_Q = QW'(NPH);

  logic [QW-1:0] triple;
  logic [QW-1:0] quarter;
  logic [QW-1:0] offset;
  logic [QW-1:0] sum;
  logic [QW-1:0] wrapped;
  logic          unused_hi;

  always_comb begin
    triple  = ({2'b00, sel_len} << 1) + {2'b00, sel_len};
    quarter = triple >> 2;
    offset  = (quarter == '0) ? '0 : (quarter - ONE_Q);
    sum     = {{(QW-PW){1'b0}}, sel_start} + offset;
    wrapped = (sum >= NPH_Q) ? (sum - NPH_Q) : sum;
  end

  assign phase     = wrapped[PW-1:0];
  assign unused_hi = ^wrapped[QW-1:PW];

endmodule

// File: rtl/phase_window_select.sv
module phase_window_select #(
  parameter int NPH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NPH-1:0]           pass_mask,
  output logic [$clog2(NPH)-1:0]   phase_out,
  output logic                     valid,
  output logic                     error
);

  import phsel_pkg::*;

  localparam int PW = $clog2(NPH);
  localparam int LW = $clog2(NPH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(NPH - 1);
  localparam logic [PW-1:0] IDX_ONE  = PW'(1);

  phsel_state_e   state;
  logic [PW-1:0]  idx;
  logic [NPH-1:0] mask_q;
  logic           step;
  logic           last;

  logic          close_v;
  logic [PW-1:0] close_start;
  logic [LW-1:0] close_len;
  logic          close_end;

  logic          head_v;
  logic [LW-1:0] head_len;
  logic          tail_v;
  logic [PW-1:0] tail_start;
  logic [LW-1:0] tail_len;
  logic [PW-1:0] mid_start;
  logic [LW-1:0] mid_len;

  logic [PW-1:0] sel_start;
  logic [LW-1:0] sel_len;
  logic          fail;
  logic [PW-1:0] pick;

  assign step = (state == ST_SCAN) && !start;
  assign last = (idx == LAST_IDX);

  phsel_run_scanner #(.NPH(NPH), .PW(PW), .LW(LW)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .clr        (start),
    .step       (step),
    .bit_in     (mask_q[idx]),
    .idx        (idx),
    .last       (last),
    .close_v    (close_v),
    .close_start(close_start),
    .close_len  (close_len),
    .close_end  (close_end)
  );

  phsel_window_acc #(.NPH(NPH), .PW(PW), .LW(LW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .clr        (start),
    .close_v    (close_v),
    .close_start(close_start),
    .close_len  (close_len),
    .close_end  (close_end),
    .head_v     (head_v),
    .head_len   (head_len),
    .tail_v     (tail_v),
    .tail_start (tail_start),
    .tail_len   (tail_len),
    .mid_start  (mid_start),
    .mid_len    (mid_len)
  );

  phsel_resolver #(.NPH(NPH), .PW(PW), .LW(LW)) u_res (
    .head_v    (head_v),
    .head_len  (head_len),
    .tail_v    (tail_v),
    .tail_start(tail_start),
    .tail_len  (tail_len),
    .mid_start (mid_start),
    .mid_len   (mid_len),
    .sel_start (sel_start),
    .sel_len   (sel_len),
    .fail      (fail)
  );

  phsel_offset_pick #(.NPH(NPH), .PW(PW), .LW(LW)) u_pick (
    .sel_start(sel_start),
    .sel_len  (sel_len),
    .phase    (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      mask_q    <= '0;
      phase_out <= '0;
      valid     <= 1'b0;
      error     <= 1'b0;
    end else if (start) begin
      state  <= ST_SCAN;
      idx    <= '0;
      mask_q <= pass_mask;
      valid  <= 1'b0;
      error  <= 1'b0;
    end else begin
      case (state)
        ST_SCAN: begin
          if (last) begin
            idx   <= '0;
            state <= ST_FIN;
          end else begin
            idx <= idx + IDX_ONE;
          end
        end
        ST_FIN: begin
          valid <= !fail;
          error <= fail;
          if (!fail) begin
            phase_out <= pick;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phsel_checker.sv
module phsel_checker #(
  parameter int NPH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic [NPH-1:0]         pass_mask,
  input logic [$clog2(NPH)-1:0] phase_out,
  input logic                   valid,
  input logic                   error
);

  localparam int CW = $clog2(NPH + 4) + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] LAT     = CW'(NPH + 1);

  logic [NPH-1:0] cap;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
      cnt <= CNT_MAX;
    end else if (start) begin
      cap <= pass_mask;
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_EXCLUSIVE_FLAGS: assert property (@(posedge clk) disable iff (rst) !(valid && error)); // R10
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst) (valid && !start) |=> (valid && $stable(phase_out))); // R10
  AST_ERROR_HELD: assert property (@(posedge clk) disable iff (rst) (error && !start) |=> error); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) start |=> (!valid && !error)); // R2
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst) $rose(valid || error) |-> (cnt == LAT)); // R2
  AST_PICK_PASSES: assert property (@(posedge clk) disable iff (rst) $rose(valid) |-> cap[phase_out]); // R3
  AST_EMPTY_ERRORS: assert property (@(posedge clk) disable iff (rst) $rose(error) |-> (cap == '0)); // R9

endmodule

bind phase_window_select phsel_checker #(.NPH(NPH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .pass_mask(pass_mask),
  .phase_out(phase_out),
  .valid    (valid),
  .error    (error)
);

// File: tb/phase_window_select_tb.sv
`timescale 1ns/1ps
module phase_window_select_tb;

  localparam int NPH = 16;
  localparam int PW  = $clog2(NPH);

  typedef struct {
    logic           err;
    int             phase;
    string          tag;
    logic [NPH-1:0] mask;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [NPH-1:0] pass_mask = '0;
  logic [PW-1:0]  phase_out;
  logic           valid;
  logic           error;

  int   checks = 0;
  int   errors = 0;
  int   since_start = 0;
  logic prev_flag = 1'b0;
  exp_t sbq[$];

  always #4 clk = ~clk;

  phase_window_select #(.NPH(NPH)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pass_mask(pass_mask),
    .phase_out(phase_out),
    .valid    (valid),
    .error    (error)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference: explicit run list, circular merge, strict-greater pick.
  function automatic void ref_pick(input logic [NPH-1:0] m, output logic err,
                                   output int ph);
    int st[NPH];
    int ln[NPH];
    int n = 0;
    int best = 0;
    int bl = 0;
    int k;
    err = 1'b0;
    ph  = 0;
    for (int p = 0; p < NPH; p++) begin
      if (m[p]) begin
        if (n > 0 && st[n-1] + ln[n-1] == p) ln[n-1]++;
        else begin st[n] = p; ln[n] = 1; n++; end
      end
    end
    if (n == 0) begin err = 1'b1; return; end
    if (n > 1 && m[0] && m[NPH-1]) begin
      if (ln[0] + ln[n-1] >= NPH) begin err = 1'b1; return; end
      ln[n-1] += ln[0];
      ln[0] = 0;
    end
    for (int i = 0; i < n; i++) begin
      if (ln[i] > bl) begin bl = ln[i]; best = i; end
    end
    k = (bl * 3) / 4;
    if (k != 0) k--;
    ph = (st[best] + k) % NPH;
  endfunction

  task automatic push_exp(input logic [NPH-1:0] m, input string tag);
    exp_t e;
    int ph;
    logic er;
    ref_pick(m, er, ph);
    e.err = er; e.phase = ph; e.tag = tag; e.mask = m;
    sbq.push_back(e);
  endtask

  task automatic pulse_start(input logic [NPH-1:0] m);
    @(negedge clk);
    start = 1'b1;
    pass_mask = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [NPH-1:0] m, input string tag);
    push_exp(m, tag);
    pulse_start(m);
    repeat (NPH + 4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (start) since_start <= 0;
    else since_start <= since_start + 1;
  end

  // Monitor: pops one expected item per new result.
  always @(negedge clk) begin
    if (!rst && (valid || error) && !prev_flag) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R11", "unexpected result count", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(since_start == NPH + 1, "R2", "latency", since_start, NPH + 1);
        check(error == e.err, e.tag, $sformatf("error flag mask %h", e.mask),
              int'(error), int'(e.err));
        check(valid == !e.err, e.tag, $sformatf("valid flag mask %h", e.mask),
              int'(valid), int'(!e.err));
        if (!e.err)
          check(int'(phase_out) == e.phase, e.tag,
                $sformatf("phase mask %h", e.mask), int'(phase_out), e.phase);
      end
    end
    prev_flag = valid || error;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NPH-1:0] lfsr;
    repeat (3) @(negedge clk);
    check(valid == 1'b0 && error == 1'b0, "R1", "flags during reset",
          int'({valid, error}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(valid == 1'b0 && error == 1'b0, "R1", "flags after reset",
          int'({valid, error}), 0);
    check(phase_out == '0, "R1", "phase after reset", int'(phase_out), 0);

    run_case(16'h0000, "R9");
    repeat (20) @(negedge clk);
    check(error && !valid, "R10", "error held", int'({valid, error}), 1);

    run_case(16'hFFFF, "R8");
    repeat (25) @(negedge clk);
    check(valid && !error && phase_out == 4'd11, "R10", "valid and phase held",
          int'(phase_out), 11);

    pulse_start(16'h0001);
    check(!valid && !error, "R2", "flags cleared after start",
          int'({valid, error}), 0);
    push_exp(16'h0001, "R7");
    repeat (NPH + 4) @(negedge clk);

    run_case(16'h00F0, "R3");
    run_case(16'hC000, "R3");
    run_case(16'h0F0F, "R4");
    run_case(16'h0E70, "R4");
    run_case(16'h8001, "R5");
    run_case(16'hE003, "R5");
    run_case(16'hF00F, "R5");
    run_case(16'hC0F3, "R6");
    run_case(16'h81E7, "R6");
    run_case(16'h7FFE, "R7");

    // R11: restart partway through a walk.
    pulse_start(16'h00F0);
    repeat (5) @(negedge clk);
    check(!valid && !error, "R11", "no result mid-walk", int'({valid, error}), 0);
    push_exp(16'hF00F, "R11");
    pulse_start(16'hF00F);
    repeat (NPH + 4) @(negedge clk);

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_case(lfsr, "R3");
    end

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R11", "results outstanding", sbq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule